// File: doc/BRIEF.md
# Aging Delay Measurement Sequencer

This block runs one aging test session for a single test pattern set. A session opens with a fail-fast test at the longest launch-to-capture period. A failure there is reported at once as sudden degradation. After a pass, the block either stops, if the set is marked for the long-period test only, or looks for the shortest capture period at which the set still passes. That search starts from a seed code, moves one level at a time, and ends when the pass/fail outcome changes.

The block does not apply patterns itself. For each test it raises a one-cycle request to an external pattern-application engine and holds a 4-bit capture-period code until the engine answers with a done pulse and a pass flag. Supply voltage and die temperature are read from sensor inputs in the cycle the engine reports done. The seed is the previously logged minimum code plus a signed correction. The correction is looked up from the voltage and temperature read during the long-period test. The result is one report: the minimum passing code, the voltage and temperature read during the test that proved it, and an error flag.

Top module: `aging_delay_seq`

## Requirements
- R1: While reset is asserted and after its release, busy_o, report_valid_o, eng_start_o, report_err_o, report_code_o, report_volt_o and report_temp_o are all zero.
- R2: A start_i accepted while idle makes the first engine request in the next cycle at code 15, the maximum of the 16 levels. Every eng_start_o pulse lasts one cycle. eng_code_o holds its value until eng_done_i returns.
- R3: If the code-15 test fails, the session ends after that single request. The report has report_err_o = 1, code 15, and the voltage and temperature read in that test's done cycle.
- R4: With full_search_i = 0 at start, a pass at code 15 ends the session after one request. The report has report_err_o = 0, code 15, and the values read in that test.
- R5: With full_search_i = 1, the second request uses seed = clamp(prev + Tbin - Vbin, 0, 15). prev is prev_code_i captured at start. Vbin and Tbin are bits [7:6] of the voltage and temperature read in the code-15 test.
- R6: If the seed test passes, each further pass lowers the code by one. On the first failure at code c, the report gives c + 1 with the voltage and temperature of the test at c + 1.
- R7: A pass at code 0 in the downward search ends the session with code 0 and that test's readings, with no further request.
- R8: If the seed test fails, each further failure raises the code by one. The first pass is reported with its own code and readings.
- R9: In the upward search, a failure at code 14 or 15 ends the session without another request. The report gives code 15 with the readings of the initial code-15 test.
- R10: busy_o is high from the first request through the cycle of report_valid_o. report_valid_o lasts exactly one cycle, and busy_o is low in the cycle after it.
- R11: start_i is ignored while busy_o is high, including in the report cycle. It changes neither the running session nor the idle state that follows.
- R12: A session whose seed lands on the true minimum (it passes there and fails one below, or fails there and passes one above) uses exactly three engine requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request a new session (taken only when idle) |
| full_search_i | input | 1 | Test strategy: 1 = search for the minimum, 0 = long-period test only |
| prev_code_i | input | 4 | Previously logged minimum passing code |
| volt_i | input | 8 | Voltage sensor reading |
| temp_i | input | 8 | Temperature sensor reading |
| eng_start_o | output | 1 | One-cycle request to the pattern engine |
| eng_code_o | output | 4 | Capture-period code for the current test |
| eng_done_i | input | 1 | Engine finished the current test |
| eng_pass_i | input | 1 | Test result, valid with eng_done_i |
| busy_o | output | 1 | Session in progress |
| report_valid_o | output | 1 | One-cycle report strobe |
| report_err_o | output | 1 | Sudden degradation (fail at code 15) |
| report_code_o | output | 4 | Minimum passing code |
| report_volt_o | output | 8 | Voltage read during the proving test |
| report_temp_o | output | 8 | Temperature read during the proving test |

## Verification
The end of one session and the request for the next can meet in the same cycle, because a start can arrive while report_valid_o is high and busy_o has not yet dropped. The bench raises start_i exactly in that report cycle, and also in the middle of a test with inverted strategy and previous code. It requires busy_o and eng_start_o to be low in the following cycle and the interrupted session's report to match the arithmetic model. A second overlap is a single done cycle that both decides the outcome and picks which stored readings are reported. Sweeping the engine's pass threshold over all 17 values against every previous code covers each source of readings.

// File: rtl/aging_seq_pkg.sv
package aging_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_ISSUE  = 3'd1,
    ST_WAIT   = 3'd2,
    ST_SEED   = 3'd3,
    ST_REPORT = 3'd4
  } seq_state_e;

  typedef enum logic [1:0] {
    PH_MAX  = 2'd0,
    PH_SEED = 2'd1,
    PH_DOWN = 2'd2,
    PH_UP   = 2'd3
  } seq_phase_e;

  typedef enum logic [1:0] {
    SRC_LIVE = 2'd0,
    SRC_INIT = 2'd1,
    SRC_PASS = 2'd2
  } vt_src_e;

endpackage

// File: rtl/vt_seed_map.sv
module vt_seed_map #(
  parameter int CODE_W = 4,
  parameter int VT_W   = 8,
  parameter int BIN_W  = 2
) (
  input  logic [CODE_W-1:0] base_code,
  input  logic [VT_W-1:0]   volt,
  input  logic [VT_W-1:0]   temp,
  output logic [CODE_W-1:0] seed_code
);
  localparam int NBIN     = 1 << BIN_W;
  localparam int CORR_W   = BIN_W + 1;
  localparam int WIDE_W   = (CODE_W > BIN_W) ? CODE_W : BIN_W;
  localparam int SUM_W    = WIDE_W + 2;
  localparam int MAX_CODE = (1 << CODE_W) - 1;

  // correction per (voltage bin, temperature bin): hotter or lower supply -> slower
  logic [CORR_W-1:0] corr_tab [NBIN*NBIN];

  for (genvar vi = 0; vi < NBIN; vi++) begin : g_vbin
    for (genvar ti = 0; ti < NBIN; ti++) begin : g_tbin
      assign corr_tab[vi*NBIN + ti] = CORR_W'(ti - vi);
    end
  end

  logic [BIN_W-1:0]        vbin;
  logic [BIN_W-1:0]        tbin;
  logic [CORR_W-1:0]       corr;
  logic signed [SUM_W-1:0] sum;

  assign vbin = volt[VT_W-1 -: BIN_W];
  assign tbin = temp[VT_W-1 -: BIN_W];
  assign corr = corr_tab[{vbin, tbin}];
  assign sum  = $signed({{(SUM_W-CODE_W){1'b0}}, base_code})
              + $signed({{(SUM_W-CORR_W){corr[CORR_W-1]}}, corr});

  always_comb begin
    if (sum[SUM_W-1]) begin
      seed_code = '0;
    end else if (sum > $signed(SUM_W'(MAX_CODE))) begin
      seed_code = CODE_W'(MAX_CODE);
    end else begin
      seed_code = sum[CODE_W-1:0];
    end
  end

endmodule

// File: rtl/vt_snapshot.sv
module vt_snapshot import aging_seq_pkg::*; #(
  parameter int VT_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [VT_W-1:0] volt_i,
  input  logic [VT_W-1:0] temp_i,
  input  logic            init_en,
  input  logic            pass_en,
  input  logic            rpt_en,
  input  vt_src_e         rpt_src,
  output logic [VT_W-1:0] init_volt,
  output logic [VT_W-1:0] init_temp,
  output logic [VT_W-1:0] rpt_volt,
  output logic [VT_W-1:0] rpt_temp
);
  localparam int NCH = 2;

  logic [VT_W-1:0] live   [NCH];
  logic [VT_W-1:0] init_q [NCH];
  logic [VT_W-1:0] init_d [NCH];
  logic [VT_W-1:0] pass_q [NCH];
  logic [VT_W-1:0] pass_d [NCH];
  logic [VT_W-1:0] rpt_q  [NCH];
  logic [VT_W-1:0] rpt_d  [NCH];

  assign live[0] = volt_i;
  assign live[1] = temp_i;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    always_comb begin
      init_d[ch] = init_q[ch];
      pass_d[ch] = pass_q[ch];
      rpt_d[ch]  = rpt_q[ch];
      if (init_en) init_d[ch] = live[ch];
      if (pass_en) pass_d[ch] = live[ch];
      if (rpt_en) begin
        case (rpt_src)
          SRC_INIT: rpt_d[ch] = init_q[ch];
          SRC_PASS: rpt_d[ch] = pass_q[ch];
          default:  rpt_d[ch] = live[ch];
        endcase
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        init_q[ch] <= '0;
        pass_q[ch] <= '0;
        rpt_q[ch]  <= '0;
      end else begin
        init_q[ch] <= init_d[ch];
        pass_q[ch] <= pass_d[ch];
        rpt_q[ch]  <= rpt_d[ch];
      end
    end
  end

  assign init_volt = init_q[0];
  assign init_temp = init_q[1];
  assign rpt_volt  = rpt_q[0];
  assign rpt_temp  = rpt_q[1];

endmodule

// File: rtl/search_ctrl.sv
module search_ctrl import aging_seq_pkg::*; #(
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              full_i,
  input  logic [CODE_W-1:0] prev_i,
  input  logic [CODE_W-1:0] seed_i,
  input  logic              done_i,
  input  logic              pass_i,
  output logic              eng_start_o,
  output logic [CODE_W-1:0] code_o,
  output logic              busy_o,
  output logic [CODE_W-1:0] prev_o,
  output logic              init_en_o,
  output logic              pass_en_o,
  output logic              rpt_en_o,
  output vt_src_e           rpt_src_o,
  output logic              report_valid_o,
  output logic              report_err_o,
  output logic [CODE_W-1:0] report_code_o
);
  localparam int MAX_CODE = (1 << CODE_W) - 1;
  localparam logic [CODE_W-1:0] TOP  = CODE_W'(MAX_CODE);
  localparam logic [CODE_W-1:0] NEAR = CODE_W'(MAX_CODE - 1);

  seq_state_e        st_q, st_d;
  seq_phase_e        ph_q, ph_d;
  logic [CODE_W-1:0] code_q, code_d;
  logic              full_q, full_d;
  logic [CODE_W-1:0] prev_q, prev_d;
  logic [CODE_W-1:0] rcode_q, rcode_d;
  logic              rerr_q, rerr_d;

  always_comb begin
    st_d      = st_q;
    ph_d      = ph_q;
    code_d    = code_q;
    full_d    = full_q;
    prev_d    = prev_q;
    rcode_d   = rcode_q;
    rerr_d    = rerr_q;
    init_en_o = 1'b0;
    pass_en_o = 1'b0;
    rpt_en_o  = 1'b0;
    rpt_src_o = SRC_LIVE;
    case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          st_d   = ST_ISSUE;
          ph_d   = PH_MAX;
          code_d = TOP;
          full_d = full_i;
          prev_d = prev_i;
        end
      end
      ST_ISSUE: st_d = ST_WAIT;
      ST_WAIT: begin
        if (done_i) begin
          if (ph_q == PH_MAX) begin
            init_en_o = 1'b1;
            if (!pass_i || !full_q) begin
              rpt_en_o = 1'b1;
              rcode_d  = TOP;
              rerr_d   = !pass_i;
              st_d     = ST_REPORT;
            end else begin
              st_d = ST_SEED;
            end
          end else if (pass_i) begin
            if (ph_q == PH_UP || code_q == '0) begin
              rpt_en_o = 1'b1;
              rcode_d  = code_q;
              rerr_d   = 1'b0;
              st_d     = ST_REPORT;
            end else begin
              pass_en_o = 1'b1;
              code_d    = code_q - 1'b1;
              ph_d      = PH_DOWN;
              st_d      = ST_ISSUE;
            end
          end else begin
            if (ph_q == PH_DOWN) begin
              rpt_en_o  = 1'b1;
              rpt_src_o = SRC_PASS;
              rcode_d   = code_q + 1'b1;
              rerr_d    = 1'b0;
              st_d      = ST_REPORT;
            end else if (code_q >= NEAR) begin
              rpt_en_o  = 1'b1;
              rpt_src_o = SRC_INIT;
              rcode_d   = TOP;
              rerr_d    = 1'b0;
              st_d      = ST_REPORT;
            end else begin
              code_d = code_q + 1'b1;
              ph_d   = PH_UP;
              st_d   = ST_ISSUE;
            end
          end
        end
      end
      ST_SEED: begin
        code_d = seed_i;
        ph_d   = PH_SEED;
        st_d   = ST_ISSUE;
      end
      ST_REPORT: st_d = ST_IDLE;
      default:   st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      ph_q    <= PH_MAX;
      code_q  <= '0;
      full_q  <= 1'b0;
      prev_q  <= '0;
      rcode_q <= '0;
      rerr_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      ph_q    <= ph_d;
      code_q  <= code_d;
      full_q  <= full_d;
      prev_q  <= prev_d;
      rcode_q <= rcode_d;
      rerr_q  <= rerr_d;
    end
  end

  assign eng_start_o    = (st_q == ST_ISSUE);
  assign busy_o         = (st_q != ST_IDLE);
  assign code_o         = code_q;
  assign prev_o         = prev_q;
  assign report_valid_o = (st_q == ST_REPORT);
  assign report_err_o   = rerr_q;
  assign report_code_o  = rcode_q;

  assert_first_at_top_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> (eng_start_o && code_o == TOP));

  assert_start_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start_o |=> !eng_start_o);

  assert_code_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WAIT) |-> $stable(code_o));

  assert_err_at_top_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (report_valid_o && report_err_o) |-> (report_code_o == TOP));

  assert_short_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (report_valid_o && !full_q) |-> (report_code_o == TOP));

  assert_report_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    report_valid_o |=> (!report_valid_o && !busy_o));

  assert_ignore_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> ($stable(prev_q) && $stable(full_q)));

endmodule

// File: rtl/aging_delay_seq.sv
module aging_delay_seq import aging_seq_pkg::*; #(
  parameter int CODE_W = 4,
  parameter int VT_W   = 8,
  parameter int BIN_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              full_search_i,
  input  logic [CODE_W-1:0] prev_code_i,
  input  logic [VT_W-1:0]   volt_i,
  input  logic [VT_W-1:0]   temp_i,
  output logic              eng_start_o,
  output logic [CODE_W-1:0] eng_code_o,
  input  logic              eng_done_i,
  input  logic              eng_pass_i,
  output logic              busy_o,
  output logic              report_valid_o,
  output logic              report_err_o,
  output logic [CODE_W-1:0] report_code_o,
  output logic [VT_W-1:0]   report_volt_o,
  output logic [VT_W-1:0]   report_temp_o
);
  logic [CODE_W-1:0] prev_q;
  logic [CODE_W-1:0] seed;
  logic [VT_W-1:0]   init_volt;
  logic [VT_W-1:0]   init_temp;
  logic              init_en;
  logic              pass_en;
  logic              rpt_en;
  vt_src_e           rpt_src;

  search_ctrl #(.CODE_W(CODE_W)) u_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .start_i        (start_i),
    .full_i         (full_search_i),
    .prev_i         (prev_code_i),
    .seed_i         (seed),
    .done_i         (eng_done_i),
    .pass_i         (eng_pass_i),
    .eng_start_o    (eng_start_o),
    .code_o         (eng_code_o),
    .busy_o         (busy_o),
    .prev_o         (prev_q),
    .init_en_o      (init_en),
    .pass_en_o      (pass_en),
    .rpt_en_o       (rpt_en),
    .rpt_src_o      (rpt_src),
    .report_valid_o (report_valid_o),
    .report_err_o   (report_err_o),
    .report_code_o  (report_code_o)
  );

  vt_snapshot #(.VT_W(VT_W)) u_snap (
    .clk       (clk),
    .rst_n     (rst_n),
    .volt_i    (volt_i),
    .temp_i    (temp_i),
    .init_en   (init_en),
    .pass_en   (pass_en),
    .rpt_en    (rpt_en),
    .rpt_src   (rpt_src),
    .init_volt (init_volt),
    .init_temp (init_temp),
    .rpt_volt  (report_volt_o),
    .rpt_temp  (report_temp_o)
  );

  vt_seed_map #(.CODE_W(CODE_W), .VT_W(VT_W), .BIN_W(BIN_W)) u_seed (
    .base_code (prev_q),
    .volt      (init_volt),
    .temp      (init_temp),
    .seed_code (seed)
  );

endmodule

// File: tb/sim_aging_delay_seq.sv
module sim_aging_delay_seq;
  localparam int CLK_PERIOD = 10;
  localparam int LAT = 2;

  logic       clk;
  logic       rst_n;
  logic       start_i;
  logic       full_search_i;
  logic [3:0] prev_code_i;
  logic [7:0] volt_i;
  logic [7:0] temp_i;
  logic       eng_start_o;
  logic [3:0] eng_code_o;
  logic       eng_done_i;
  logic       eng_pass_i;
  logic       busy_o;
  logic       report_valid_o;
  logic       report_err_o;
  logic [3:0] report_code_o;
  logic [7:0] report_volt_o;
  logic [7:0] report_temp_o;

  int  n_checks = 0;
  int  n_errors = 0;
  bit  finished = 0;

  aging_delay_seq u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .full_search_i(full_search_i),
    .prev_code_i(prev_code_i), .volt_i(volt_i), .temp_i(temp_i),
    .eng_start_o(eng_start_o), .eng_code_o(eng_code_o),
    .eng_done_i(eng_done_i), .eng_pass_i(eng_pass_i),
    .busy_o(busy_o), .report_valid_o(report_valid_o), .report_err_o(report_err_o),
    .report_code_o(report_code_o), .report_volt_o(report_volt_o),
    .report_temp_o(report_temp_o)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic run_session(input int thr, input int prev, input int vb,
                             input int tb, input bit full, input bit poke);
    int seed, exp_code, exp_err, exp_idx, exp_tests, tests, cur, guard;
    int vbase, tbase;
    string tag, ctag;
    vbase = vb*64 + 8;
    tbase = tb*64 + 20;
    seed = prev + tb - vb;
    if (seed < 0) seed = 0;
    if (seed > 15) seed = 15;
    if (thr > 15) begin
      exp_err = 1; exp_code = 15; exp_idx = 0; exp_tests = 1; tag = "R3";
    end else if (!full) begin
      exp_err = 0; exp_code = 15; exp_idx = 0; exp_tests = 1; tag = "R4";
    end else if (seed >= thr) begin
      exp_err = 0; exp_code = thr; exp_idx = 1 + seed - thr;
      exp_tests = 2 + seed - thr + ((thr > 0) ? 1 : 0);
      tag = (thr == 0) ? "R7" : "R6";
    end else if (thr < 15) begin
      exp_err = 0; exp_code = thr; exp_idx = 1 + thr - seed;
      exp_tests = 2 + thr - seed; tag = "R8";
    end else begin
      exp_err = 0; exp_code = 15; exp_idx = 0; exp_tests = 16 - seed; tag = "R9";
    end
    ctag = (full && thr <= 15 && (seed == thr || seed == thr - 1) && exp_tests == 3)
           ? "R12" : tag;

    @(negedge clk);
    prev_code_i   = 4'(prev);
    full_search_i = full;
    start_i       = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(eng_start_o && eng_code_o == 4'd15, "R2", "first request at code 15",
        int'(eng_code_o), 15);
    chk(busy_o, "R10", "busy after start", int'(busy_o), 1);

    tests = 0;
    guard = 0;
    while (!report_valid_o && guard < 400) begin
      guard++;
      if (eng_start_o) begin
        cur = int'(eng_code_o);
        chk(busy_o, "R10", "busy during request", int'(busy_o), 1);
        if (tests == 1 && full && thr <= 15)
          chk(cur == seed, "R5", "seed code", cur, seed);
        volt_i = 8'(vbase + tests);
        temp_i = 8'(tbase + 2*tests);
        tests++;
        if (poke && tests == 2) begin
          start_i       = 1'b1;
          prev_code_i   = 4'(15 - prev);
          full_search_i = !full;
        end
        repeat (LAT) @(negedge clk);
        start_i    = 1'b0;
        eng_done_i = 1'b1;
        eng_pass_i = (cur >= thr);
        @(negedge clk);
        eng_done_i = 1'b0;
        eng_pass_i = 1'b0;
      end else begin
        @(negedge clk);
      end
    end

    chk(report_valid_o, "R10", "report strobe seen", int'(report_valid_o), 1);
    chk(busy_o, "R10", "busy in report cycle", int'(busy_o), 1);
    chk(int'(report_code_o) == exp_code, tag, "report code", int'(report_code_o), exp_code);
    chk(int'(report_err_o) == exp_err, tag, "error flag", int'(report_err_o), exp_err);
    chk(int'(report_volt_o) == ((vbase + exp_idx) & 255), tag, "report voltage",
        int'(report_volt_o), (vbase + exp_idx) & 255);
    chk(int'(report_temp_o) == ((tbase + 2*exp_idx) & 255), tag, "report temperature",
        int'(report_temp_o), (tbase + 2*exp_idx) & 255);
    chk(tests == exp_tests, ctag, "engine request count", tests, exp_tests);

    if (poke) begin
      start_i       = 1'b1;
      full_search_i = 1'b1;
      prev_code_i   = 4'(prev ^ 5);
    end
    @(negedge clk);
    start_i = 1'b0;
    chk(!busy_o, "R10", "busy low after report", int'(busy_o), 0);
    chk(!report_valid_o, "R10", "report strobe one cycle", int'(report_valid_o), 0);
    chk(!eng_start_o, "R11", "no session from start during report", int'(eng_start_o), 0);
  endtask

  initial begin
    rst_n = 1'b0; start_i = 1'b0; full_search_i = 1'b0; prev_code_i = '0;
    volt_i = '0; temp_i = '0; eng_done_i = 1'b0; eng_pass_i = 1'b0;
    repeat (3) @(negedge clk);
    chk(!busy_o && !report_valid_o && !eng_start_o, "R1", "control outputs in reset",
        int'({busy_o, report_valid_o, eng_start_o}), 0);
    chk(report_code_o == '0 && !report_err_o, "R1", "report code and flag in reset",
        int'({report_err_o, report_code_o}), 0);
    chk(report_volt_o == '0 && report_temp_o == '0, "R1", "report readings in reset",
        int'({report_volt_o, report_temp_o}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy_o && !eng_start_o && !report_valid_o, "R1", "idle after reset release",
        int'({busy_o, eng_start_o, report_valid_o}), 0);

    for (int combo = 0; combo < 3; combo++) begin
      for (int thr = 0; thr <= 16; thr++) begin
        for (int prev = 0; prev < 16; prev++) begin
          run_session(thr, prev, (combo == 0) ? 0 : (combo == 1) ? 2 : 3,
                      (combo == 0) ? 3 : (combo == 1) ? 2 : 0, 1'b1, (prev % 5) == 0);
        end
      end
      for (int k = 0; k < 4; k++) begin
        run_session((k == 3) ? 16 : k*5, 3 + k, combo, 2 - (combo % 2), 1'b0, k[0]);
      end
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 190000);
    if (!finished) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

endmodule